// File: doc/BRIEF.md
# Audio Clock Ratio Auto-Detector

This block watches the bit clock and frame sync of an incoming audio serial port on which the chip is the clock follower. It works out how many bit clocks fall in each frame and which standard sample rate the frame period belongs to. It also decides whether the pair may be used, so that the internal clock dividers can be set up from the incoming clocks alone, with no host programming.

Both audio clocks are sampled by a fast reference clock `clk`. The number of bit-clock rising edges between two frame-sync rising edges gives the ratio. The number of reference cycles over the same frame gives the frame period, which is matched against the fourteen legal rates in two families. The parameter `BASE_CNT` is the nominal number of reference cycles in one frame at 192 kHz. A lock flag reports stable measurements, and a separate flag reports pairs that are malformed or reserved. The reserved pairs depend on a supply-range select input.

Top module: `clk_ratio_detect`

## Requirements
- R1: The ratio is the count of bit-clock rising edges between consecutive frame-sync rising edges. The legal ratios are encoded on `ratioCode` as 0=16, 1=24, 2=32, 3=48, 4=64, 5=96, 6=128, 7=192, 8=256, 9=384, 10=512.
- R2: A frame matches a rate when its reference-cycle count lies within nominal ±nominal/32. The nominal count is `BASE_CNT`×m, with m = 24, 12, 8, 6, 4, 2, 1 for `rateCode` 0..6. Those codes stand for 8/16/24/32/48/96/192 kHz when `rateFamily`=0 and 7.35/14.7/22.05/29.4/44.1/88.2/176.4 kHz when `rateFamily`=1. In family 1 the nominal count is multiplied by 160/147.
- R3: After reset or a timeout, the first frame-sync rise only starts measurement. `locked` rises when a frame with a legal ratio and a matched rate gives the same ratio, rate and family as the frame before it, which must also be valid.
- R4: A completed frame that differs from the previous one, or that is not valid, clears `locked`.
- R5: If no frame-sync rise arrives within 5/4 of the longest nominal frame, `locked` clears and detection starts over as after reset.
- R6: `ratioCode`, `rateCode` and `rateFamily` change only in the cycle where `locked` rises. At all other times they hold their last locked values.
- R7: `unsupported` is set at the end of a frame whose ratio is not legal or whose period matches no rate.
- R8: A pair is reserved, and `unsupported` is set, when ratio > C×m, with C=128 when `supplyHigh`=1 and C=64 when it is 0. The supply select is sampled at the end of each frame.
- R9: At low rates, small ratios are reserved: in family 0 when 3×ratio < 4×m, and in family 1 when ratio < 2×m. Ratio 16 at 22.05 kHz stays supported.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Synchronous reset, active low |
| bclkIn | input | 1 | Incoming bit clock (asynchronous) |
| fsyncIn | input | 1 | Incoming frame sync (asynchronous) |
| supplyHigh | input | 1 | 1 selects the high supply range (higher bit-clock ceiling) |
| ratioCode | output | 4 | Locked ratio code (R1) |
| rateCode | output | 3 | Locked rate code (R2) |
| rateFamily | output | 1 | 0 for the 48 kHz family, 1 for the 44.1 kHz family |
| locked | output | 1 | Two matching valid frames in a row |
| unsupported | output | 1 | Latest frame was malformed or reserved |

## Verification
The end of a frame and the frame timeout can arrive in the same reference cycle. The end of a frame can also coincide with a change of the supply select. In the first case the frame-end evaluation wins, and its period matches no rate, so lock still drops. The assertions check this cycle by cycle. The supply change is provoked by flipping `supplyHigh` between two identical frames at ratio 192 and 96 kHz. The result is judged by `unsupported` going from 0 to 1 with no change in the bit-clock stimulus.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int NUM_RATIOS = 11;
  localparam int NUM_RATES  = 7;

  typedef struct packed {
    logic       edgeSeen;
    logic       timeoutHit;
    logic       ratioLegal;
    logic [3:0] ratioIdx;
    logic       rateLegal;
    logic [2:0] rateIdx;
    logic       family;
    logic       reserved;
  } meas_t;

  typedef struct packed {
    logic restart;
  } strobe_t;

  // Ratio value for a ratio code: even codes 16<<k, odd codes 24<<k
  function automatic int ratioValue(input int idx);
    return ((idx % 2) != 0 ? 24 : 16) << (idx / 2);
  endfunction

  // Frame-length multiple of the 192 kHz frame for a rate code
  function automatic int rateMult(input int idx);
    case (idx)
      0: return 24;
      1: return 12;
      2: return 8;
      3: return 6;
      4: return 4;
      5: return 2;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/clk_ratio_dp.sv
module clk_ratio_dp
  import clk_ratio_pkg::*;
#(
  parameter int BASE_CNT  = 1024,
  parameter int MAX_RATIO = 512
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bclkIn,
  input  logic    fsyncIn,
  input  logic    supplyHigh,
  input  strobe_t strb,
  output meas_t   meas
);
  localparam int LONGEST = BASE_CNT * 24 * 160 / 147;
  localparam int TIMEOUT = LONGEST + LONGEST / 4;
  localparam int FRAME_W = $clog2(TIMEOUT + 1);
  localparam int BCLK_W  = $clog2(MAX_RATIO * 2) + 1;
  localparam int NUM_CLS = 2 * NUM_RATES;

  logic [2:0] bclkSync, fsyncSync;
  logic bclkRise, fsyncRise;
  logic [FRAME_W-1:0] frameCnt;
  logic [BCLK_W-1:0]  bclkCnt;
  logic [NUM_CLS-1:0] rateHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkSync  <= '0;
      fsyncSync <= '0;
    end else begin
      bclkSync  <= {bclkSync[1:0], bclkIn};
      fsyncSync <= {fsyncSync[1:0], fsyncIn};
    end
  end

  assign bclkRise  = bclkSync[1] && !bclkSync[2];
  assign fsyncRise = fsyncSync[1] && !fsyncSync[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      bclkCnt  <= '0;
    end else if (strb.restart) begin
      frameCnt <= FRAME_W'(1);
      bclkCnt  <= bclkRise ? BCLK_W'(1) : '0;
    end else begin
      if (frameCnt != FRAME_W'(TIMEOUT)) frameCnt <= frameCnt + 1'b1;
      if (bclkRise && bclkCnt != '1)      bclkCnt  <= bclkCnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_rate
    localparam int FAM = g / NUM_RATES;
    localparam int NOM = (FAM != 0) ? BASE_CNT * rateMult(g % NUM_RATES) * 160 / 147
                                    : BASE_CNT * rateMult(g % NUM_RATES);
    localparam int TOL = NOM >> 5;
    assign rateHit[g] = (frameCnt >= FRAME_W'(NOM - TOL)) && (frameCnt <= FRAME_W'(NOM + TOL));
  end

  always_comb begin
    int rv;
    int m;
    int ceilMul;
    meas            = '0;
    meas.edgeSeen   = fsyncRise;
    meas.timeoutHit = (frameCnt == FRAME_W'(TIMEOUT));
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (bclkCnt == BCLK_W'(ratioValue(i))) begin
        meas.ratioLegal = 1'b1;
        meas.ratioIdx   = 4'(i);
      end
    end
    for (int i = NUM_CLS - 1; i >= 0; i--) begin
      if (rateHit[i]) begin
        meas.rateLegal = 1'b1;
        meas.rateIdx   = 3'(i % NUM_RATES);
        meas.family    = (i >= NUM_RATES);
      end
    end
    rv      = ratioValue(int'(meas.ratioIdx));
    m       = rateMult(int'(meas.rateIdx));
    ceilMul = supplyHigh ? 128 : 64;
    meas.reserved = (rv > ceilMul * m) ||
                    (meas.family ? (rv < 2 * m) : (3 * rv < 4 * m));
  end
endmodule

// File: rtl/clk_ratio_ctl.sv
module clk_ratio_ctl
  import clk_ratio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  meas_t      meas,
  output strobe_t    strb,
  output logic [3:0] ratioCode,
  output logic [2:0] rateCode,
  output logic       rateFamily,
  output logic       locked,
  output logic       unsupported
);
  logic       armed, havePrev;
  logic [3:0] prevRatio;
  logic [2:0] prevRate;
  logic       prevFam;
  logic       frameValid, sameAsPrev;

  assign strb.restart = meas.edgeSeen || meas.timeoutHit;
  assign frameValid   = meas.ratioLegal && meas.rateLegal;
  assign sameAsPrev   = havePrev && (prevRatio == meas.ratioIdx) &&
                        (prevRate == meas.rateIdx) && (prevFam == meas.family);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed       <= 1'b0;
      havePrev    <= 1'b0;
      prevRatio   <= '0;
      prevRate    <= '0;
      prevFam     <= 1'b0;
      locked      <= 1'b0;
      unsupported <= 1'b0;
      ratioCode   <= '0;
      rateCode    <= '0;
      rateFamily  <= 1'b0;
    end else if (meas.edgeSeen) begin
      if (!armed) begin
        armed <= 1'b1;
      end else begin
        havePrev    <= frameValid;
        prevRatio   <= meas.ratioIdx;
        prevRate    <= meas.rateIdx;
        prevFam     <= meas.family;
        unsupported <= !frameValid || meas.reserved;
        if (frameValid && sameAsPrev) begin
          locked     <= 1'b1;
          ratioCode  <= meas.ratioIdx;
          rateCode   <= meas.rateIdx;
          rateFamily <= meas.family;
        end else begin
          locked <= 1'b0;
        end
      end
    end else if (meas.timeoutHit) begin
      locked   <= 1'b0;
      armed    <= 1'b0;
      havePrev <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import clk_ratio_pkg::*;
#(
  parameter int BASE_CNT  = 1024,
  parameter int MAX_RATIO = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclkIn,
  input  logic       fsyncIn,
  input  logic       supplyHigh,
  output logic [3:0] ratioCode,
  output logic [2:0] rateCode,
  output logic       rateFamily,
  output logic       locked,
  output logic       unsupported
);
  meas_t   meas;
  strobe_t strb;

  clk_ratio_dp #(.BASE_CNT(BASE_CNT), .MAX_RATIO(MAX_RATIO)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .bclkIn     (bclkIn),
    .fsyncIn    (fsyncIn),
    .supplyHigh (supplyHigh),
    .strb       (strb),
    .meas       (meas)
  );

  clk_ratio_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .meas        (meas),
    .strb        (strb),
    .ratioCode   (ratioCode),
    .rateCode    (rateCode),
    .rateFamily  (rateFamily),
    .locked      (locked),
    .unsupported (unsupported)
  );
endmodule

// File: rtl/clk_ratio_detect_chk.sv
module clk_ratio_detect_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameEdge,
  input logic       timeoutHit,
  input logic [3:0] ratioCode,
  input logic [2:0] rateCode,
  input logic       rateFamily,
  input logic       locked,
  input logic       unsupported
);
  p_lock_on_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(frameEdge));

  p_timeout_unlock_r5: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHit |=> !locked);

  p_codes_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({ratioCode, rateCode, rateFamily}) |-> $rose(locked));

  p_unsup_on_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(unsupported) |-> $past(frameEdge));

  p_code_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (ratioCode <= 4'd10) && (rateCode <= 3'd6));
endmodule

bind clk_ratio_detect clk_ratio_detect_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameEdge   (meas.edgeSeen),
  .timeoutHit  (meas.timeoutHit),
  .ratioCode   (ratioCode),
  .rateCode    (rateCode),
  .rateFamily  (rateFamily),
  .locked      (locked),
  .unsupported (unsupported)
);

// File: tb/clk_ratio_detect_tb.sv
`timescale 1ns/1ps
module clk_ratio_detect_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclkIn = 1'b0;
  logic fsyncIn = 1'b0;
  logic supplyHigh = 1'b1;
  logic [3:0] ratioCode;
  logic [2:0] rateCode;
  logic rateFamily, locked, unsupported;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clk_ratio_detect #(.BASE_CNT(768), .MAX_RATIO(512)) u_dut (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .fsyncIn(fsyncIn),
    .supplyHigh(supplyHigh), .ratioCode(ratioCode), .rateCode(rateCode),
    .rateFamily(rateFamily), .locked(locked), .unsupported(unsupported));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // n frames of ratio bit clocks, each bit clock 2*h reference cycles
  task automatic sendFrames(input int h, input int ratio, input int n);
    for (int f = 0; f < n; f++) begin
      for (int b = 0; b < ratio; b++) begin
        fsyncIn = (b < ratio / 2);
        bclkIn  = 1'b0;
        repeat (h) @(negedge clk);
        bclkIn  = 1'b1;
        repeat (h) @(negedge clk);
      end
    end
  endtask

  task automatic checkCodes(input string req, input int r, input int t, input int fam);
    check({req, " ratioCode"}, ratioCode, r);
    check({req, " rateCode"}, rateCode, t);
    check({req, " rateFamily"}, rateFamily, fam);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 locked", locked, 0);
    check("R10 unsupported", unsupported, 0);
    checkCodes("R10", 0, 0, 0);
  endtask

  task automatic t_lock48();
    sendFrames(24, 64, 3);               // 64 x 48 kHz
    check("R3 locked", locked, 1);
    checkCodes("R1 R2", 4, 4, 0);
    check("R8 unsupported", unsupported, 0);
  endtask

  task automatic t_switch441();
    sendFrames(26, 64, 2);               // 64 x 44.1 kHz
    check("R4 locked", locked, 0);
    checkCodes("R6 hold", 4, 4, 0);
    sendFrames(26, 64, 1);
    check("R3 relock", locked, 1);
    checkCodes("R2 family", 4, 4, 1);
  endtask

  task automatic t_badRate();
    sendFrames(44, 64, 2);               // period between legal rates
    check("R7 rate unmatched", unsupported, 1);
    check("R4 locked", locked, 0);
  endtask

  task automatic t_ceiling();
    sendFrames(2, 192, 2);               // 192 x 192 kHz, above high ceiling
    check("R8 over high ceiling", unsupported, 1);
    sendFrames(3, 128, 2);               // 128 x 192 kHz, at ceiling
    check("R8 at high ceiling", unsupported, 0);
  endtask

  task automatic t_badRatio();
    sendFrames(64, 36, 2);               // 36 x 32 kHz
    check("R7 ratio illegal", unsupported, 1);
    check("R4 locked", locked, 0);
  endtask

  task automatic t_supply();
    sendFrames(4, 192, 2);               // 192 x 96 kHz
    check("R8 high supply", unsupported, 0);
    supplyHigh = 1'b0;
    sendFrames(4, 192, 1);
    check("R8 low supply", unsupported, 1);
    supplyHigh = 1'b1;
  endtask

  task automatic t_lowRate2205();
    sendFrames(209, 16, 3);              // 16 x 22.05 kHz
    check("R9 16 at 22.05k", unsupported, 0);
    check("R3 locked", locked, 1);
    checkCodes("R9", 0, 2, 1);
  endtask

  task automatic t_timeout();
    fsyncIn = 1'b0;
    bclkIn  = 1'b0;
    repeat (26000) @(negedge clk);
    check("R5 timeout", locked, 0);
    checkCodes("R6 hold after timeout", 0, 2, 1);
  endtask

  task automatic t_lowRate8k();
    sendFrames(384, 24, 2);              // 24 x 8 kHz
    check("R9 24 at 8k", unsupported, 1);
    sendFrames(24, 64, 2);
    check("R4 locked", locked, 0);
    checkCodes("R5 relock then R6 hold", 1, 0, 0);
    sendFrames(24, 64, 1);
    check("R5 relock", locked, 1);
    checkCodes("R1 R2", 4, 4, 0);
    check("R8 unsupported", unsupported, 0);
  endtask

  task automatic t_lowRate147();
    sendFrames(313, 16, 2);              // 16 x 14.7 kHz
    check("R9 16 at 14.7k", unsupported, 1);
  endtask

  initial begin
    t_reset();
    t_lock48();
    t_switch441();
    t_badRate();
    t_ceiling();
    t_badRatio();
    t_supply();
    t_lowRate2205();
    t_timeout();
    t_lowRate8k();
    t_lowRate147();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (198000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule